// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits between a processor-side address bus and a bus bridge. It holds ten programmable address windows: one base memory bank, four plug-in memory banks (SIMM slots), two outbound PCI memory windows, one outbound PCI I/O window and two inbound PCI target windows. Each window has a 32-bit configuration word, loaded through a single-cycle register-write port that selects the word by index.

For every lookup request the block compares the address against all enabled windows in parallel. It picks one winner by fixed priority and returns three things one clock later: a one-hot hit vector, the translated address for the winner, and a miss flag. Memory banks pass the address through unchanged. Master and target windows replace the upper address bits with a programmed local base, keeping the offset inside the window. A lookup is issued by pulsing the request valid. Software reprograms a window by writing its word, and lookups starting in the following cycle use the new value.

Top module: `aw_window_decoder`

## Requirements
- R1: After reset every configuration word is zero, so all windows are disabled. The response outputs are all zero (valid, hit vector, address and miss). Every lookup misses until a window is written.
- R2: A master window (index 5, 6 or 7) is enabled by config bit 12 and starts at config bits 31:24 placed at address bits 31:24. Config bits 19:13 form a compare mask for address bits 30:24, where a set bit means the address bit is compared, and address bit 31 is always compared. The window covers start through start OR the inverse of the compared-bit pattern.
- R3: A master window translates to config bits 7:0 placed at address bits 31:24, ORed with the offset of the address from the window start.
- R4: A target window (index 8 or 9) is enabled by config bit 12 and starts at config bits 31:21 placed at address bits 31:21. Config bits 19:13 form a compare mask for address bits 27:21, and address bits 31:28 are always compared.
- R5: A target window translates to config bits 10:0 shifted left by 21, ORed with the offset from the window start.
- R6: The base memory bank (index 0) is enabled by config bit 3 and starts at config bits 27:22 placed at address bits 27:22. Its size is 4 MB, doubled for each of bits 14 and then 15 that is clear, stopping at the first set bit (4, 8 or 16 MB). It translates to the unchanged address.
- R7: Each SIMM bank (index 1 to 4) is enabled by config bit 3 and starts at config bits 27:21 placed at address bits 27:21. Its size is 2 MB, doubled for each of bits 13 through 17 that is clear, stopping at the first set bit (2 MB up to 64 MB). It translates to the unchanged address.
- R8: When several windows hit, the lowest index wins: bank, SIMM 0 to 3, master 1, master 2, I/O, target 1, target 2. Bit i of the hit vector marks window index i, and at most one bit is set.
- R9: When no enabled window contains the address, the miss flag is 1, the hit vector is zero and the translated address is zero. On a hit the miss flag is 0.
- R10: The response is registered. The response valid is high exactly in the cycle after the request valid. Hit, address and miss hold their values while no request is made. A configuration write is seen by lookups issued in the next cycle.
- R11: A configuration write whose index is 10 or above changes no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | 4 | Window index of the configuration word to write |
| cfg_wr_data | input | 32 | Configuration word |
| req_vld | input | 1 | Lookup request valid |
| req_addr | input | 32 | Address to look up |
| rsp_vld | output | 1 | Lookup response valid, one cycle after the request |
| rsp_hit | output | 10 | One-hot hit vector of the winning window |
| rsp_addr | output | 32 | Translated address of the winner, zero on a miss |
| rsp_miss | output | 1 | No enabled window contains the address |

## Verification
The assertions assume that no request is issued until the internal reset synchronizer has released, because the response-valid property is checked against the synchronized reset. They also assume that the window range arithmetic never wraps past the top of the address space, which the field layout guarantees for every bank and SIMM setting. The bench waits several cycles after releasing reset before its first lookup. It places bank and SIMM windows low enough that start plus size stays below 4 GB, and it drives every overlap case on purpose so that the priority order is the only thing deciding the winner.

// File: rtl/aw_pkg.sv
package aw_pkg;

  localparam int AW = 32;

  typedef enum logic [1:0] {
    WK_BANK,
    WK_SIMM,
    WK_MASTER,
    WK_TARGET
  } win_kind_e;

  // Field positions shared by the window kinds
  localparam int MT_EN_BIT   = 12;
  localparam int MT_MASK_LO  = 13;
  localparam int MT_MASK_HI  = 19;
  localparam int MEM_EN_BIT  = 3;
  localparam int BANK_SZ_LO  = 14;
  localparam int SIMM_SZ_LO  = 13;

  localparam logic [AW-1:0] BANK_MIN_SIZE = 32'h0040_0000;
  localparam logic [AW-1:0] SIMM_MIN_SIZE = 32'h0020_0000;

  // Window index layout: bank, SIMMs, two memory masters, I/O master, two targets
  function automatic win_kind_e kind_of(input int idx, input int nsimm);
    if (idx == 0)              return WK_BANK;
    else if (idx <= nsimm)     return WK_SIMM;
    else if (idx <= nsimm + 3) return WK_MASTER;
    else                       return WK_TARGET;
  endfunction

endpackage

// File: rtl/aw_cfg_regs.sv
module aw_cfg_regs
  import aw_pkg::*;
#(
  parameter int NWIN  = 10,
  parameter int IDX_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [AW-1:0]             wr_data,
  output logic [NWIN-1:0][AW-1:0]   cfg_o
);

  for (genvar g = 0; g < NWIN; g++) begin : g_word
    logic          sel;
    logic [AW-1:0] word_d;
    logic [AW-1:0] word_q;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      word_d = word_q;
      if (sel) begin
        word_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (sel) begin
        word_q <= word_d;
      end
    end

    assign cfg_o[g] = word_q;
  end

endmodule

// File: rtl/aw_window_match.sv
module aw_window_match
  import aw_pkg::*;
#(
  parameter win_kind_e KIND = WK_MASTER
) (
  input  logic [AW-1:0] cfg_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [AW-1:0] xlat_o
);

  logic [AW-1:0] win_lo;
  logic [AW-1:0] win_hi;
  logic          win_en;

  if (KIND == WK_MASTER) begin : g_master
    logic [AW-1:0] cmp_bits;
    logic          unused_fields;
    assign cmp_bits      = {1'b1, cfg_i[MT_MASK_HI:MT_MASK_LO], 24'h0};
    assign win_en        = cfg_i[MT_EN_BIT];
    assign win_lo        = {cfg_i[31:24], 24'h0};
    assign win_hi        = win_lo | ~cmp_bits;
    assign xlat_o        = {cfg_i[7:0], 24'h0} | (addr_i - win_lo);
    assign unused_fields = ^{cfg_i[23:20], cfg_i[11:8]};
  end else if (KIND == WK_TARGET) begin : g_target
    logic [AW-1:0] cmp_bits;
    logic          unused_fields;
    assign cmp_bits      = {4'hF, cfg_i[MT_MASK_HI:MT_MASK_LO], 21'h0};
    assign win_en        = cfg_i[MT_EN_BIT];
    assign win_lo        = {cfg_i[31:21], 21'h0};
    assign win_hi        = win_lo | ~cmp_bits;
    assign xlat_o        = {cfg_i[10:0], 21'h0} | (addr_i - win_lo);
    assign unused_fields = cfg_i[20] ^ cfg_i[11];
  end else if (KIND == WK_BANK) begin : g_bank
    logic [1:0]    sz_shift;
    logic          unused_fields;
    always_comb begin
      if (cfg_i[BANK_SZ_LO])          sz_shift = 2'd0;
      else if (cfg_i[BANK_SZ_LO + 1]) sz_shift = 2'd1;
      else                            sz_shift = 2'd2;
    end
    assign win_en        = cfg_i[MEM_EN_BIT];
    assign win_lo        = {4'h0, cfg_i[27:22], 22'h0};
    assign win_hi        = win_lo + (BANK_MIN_SIZE << sz_shift) - 32'd1;
    assign xlat_o        = addr_i;
    assign unused_fields = ^{cfg_i[31:28], cfg_i[21:16], cfg_i[13:4], cfg_i[2:0]};
  end else begin : g_simm
    logic [2:0]    sz_shift;
    logic          unused_fields;
    always_comb begin
      sz_shift = 3'd5;
      for (int b = 4; b >= 0; b--) begin
        if (cfg_i[SIMM_SZ_LO + b]) begin
          sz_shift = 3'(b);
        end
      end
    end
    assign win_en        = cfg_i[MEM_EN_BIT];
    assign win_lo        = {4'h0, cfg_i[27:21], 21'h0};
    assign win_hi        = win_lo + (SIMM_MIN_SIZE << sz_shift) - 32'd1;
    assign xlat_o        = addr_i;
    assign unused_fields = ^{cfg_i[31:28], cfg_i[20:18], cfg_i[12:4], cfg_i[2:0]};
  end

  assign hit_o = win_en && (addr_i >= win_lo) && (addr_i <= win_hi);

endmodule

// File: rtl/aw_prio_sel.sv
module aw_prio_sel
  import aw_pkg::*;
#(
  parameter int NWIN = 10
) (
  input  logic [NWIN-1:0]           hit_i,
  input  logic [NWIN-1:0][AW-1:0]   xlat_i,
  output logic [NWIN-1:0]           grant_o,
  output logic [AW-1:0]             xlat_o,
  output logic                      none_o
);

  // Scan from the highest index down so the lowest index is the last to win
  always_comb begin
    grant_o = '0;
    xlat_o  = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        xlat_o     = xlat_i[i];
      end
    end
  end

  assign none_o = ~|hit_i;

endmodule

// File: rtl/aw_window_decoder.sv
module aw_window_decoder
  import aw_pkg::*;
#(
  parameter  int NUM_SIMM = 4,
  localparam int NWIN     = NUM_SIMM + 6,
  localparam int IDX_W    = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_wr_idx,
  input  logic [AW-1:0]     cfg_wr_data,
  input  logic              req_vld,
  input  logic [AW-1:0]     req_addr,
  output logic              rsp_vld,
  output logic [NWIN-1:0]   rsp_hit,
  output logic [AW-1:0]     rsp_addr,
  output logic              rsp_miss
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [NWIN-1:0][AW-1:0] cfg_words;

  aw_cfg_regs #(
    .NWIN  (NWIN),
    .IDX_W (IDX_W)
  ) cfg_regs_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_wr_en),
    .wr_idx  (cfg_wr_idx),
    .wr_data (cfg_wr_data),
    .cfg_o   (cfg_words)
  );

  logic [NWIN-1:0]         win_hit;
  logic [NWIN-1:0][AW-1:0] win_xlat;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    aw_window_match #(
      .KIND (kind_of(g, NUM_SIMM))
    ) match_i (
      .cfg_i  (cfg_words[g]),
      .addr_i (req_addr),
      .hit_o  (win_hit[g]),
      .xlat_o (win_xlat[g])
    );
  end

  logic [NWIN-1:0] sel_grant;
  logic [AW-1:0]   sel_xlat;
  logic            sel_none;

  aw_prio_sel #(
    .NWIN (NWIN)
  ) prio_i (
    .hit_i   (win_hit),
    .xlat_i  (win_xlat),
    .grant_o (sel_grant),
    .xlat_o  (sel_xlat),
    .none_o  (sel_none)
  );

  // Response stage: next-state and register processes
  logic            vld_d,  vld_q;
  logic [NWIN-1:0] hit_d,  hit_q;
  logic [AW-1:0]   addr_d, addr_q;
  logic            miss_d, miss_q;
  logic            rsp_ce;

  assign rsp_ce = req_vld;

  always_comb begin
    vld_d  = req_vld;
    hit_d  = sel_grant;
    addr_d = sel_xlat;
    miss_d = sel_none;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hit_q  <= '0;
      addr_q <= '0;
      miss_q <= 1'b0;
    end else if (rsp_ce) begin
      hit_q  <= hit_d;
      addr_q <= addr_d;
      miss_q <= miss_d;
    end
  end

  assign rsp_vld  = vld_q;
  assign rsp_hit  = hit_q;
  assign rsp_addr = addr_q;
  assign rsp_miss = miss_q;

endmodule

// File: rtl/aw_window_decoder_chk.sv
module aw_window_decoder_chk
  import aw_pkg::*;
#(
  parameter int NWIN  = 10,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [IDX_W-1:0] cfg_wr_idx,
  input logic             req_vld,
  input logic             rsp_vld,
  input logic [NWIN-1:0]  rsp_hit,
  input logic [AW-1:0]    rsp_addr,
  input logic             rsp_miss
);

  logic any_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_wr_q <= 1'b0;
    end else if (cfg_wr_en && (cfg_wr_idx < IDX_W'(NWIN))) begin
      any_wr_q <= 1'b1;
    end
  end

  // R1
  reset_all_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !any_wr_q) |-> rsp_miss);

  // R8
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_hit));

  // R9
  miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> (rsp_miss == (rsp_hit == '0)));

  // R9
  miss_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_miss) |-> (rsp_addr == '0));

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);

  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(rsp_hit) && $stable(rsp_addr) && $stable(rsp_miss)));

endmodule

bind aw_window_decoder aw_window_decoder_chk #(
  .NWIN  (NWIN),
  .IDX_W (IDX_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_wr_idx (cfg_wr_idx),
  .req_vld    (req_vld),
  .rsp_vld    (rsp_vld),
  .rsp_hit    (rsp_hit),
  .rsp_addr   (rsp_addr),
  .rsp_miss   (rsp_miss)
);

// File: tb/aw_window_decoder_tb_top.sv
module aw_window_decoder_tb_top;

  localparam int NW = 10;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [3:0]  cfg_wr_idx;
  logic [31:0] cfg_wr_data;
  logic        req_vld;
  logic [31:0] req_addr;
  logic        rsp_vld;
  logic [NW-1:0] rsp_hit;
  logic [31:0] rsp_addr;
  logic        rsp_miss;

  aw_window_decoder dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_idx  (cfg_wr_idx),
    .cfg_wr_data (cfg_wr_data),
    .req_vld     (req_vld),
    .req_addr    (req_addr),
    .rsp_vld     (rsp_vld),
    .rsp_hit     (rsp_hit),
    .rsp_addr    (rsp_addr),
    .rsp_miss    (rsp_miss)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [NW-1:0] hit;
    logic [31:0]   addr;
    logic          miss;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [31:0] shadow [NW];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  bit live  = 0;

  // Reference model written from the requirement text
  function automatic void ref_win(input int i, input logic [31:0] c, input logic [31:0] a,
                                  output bit h, output logic [31:0] x);
    logic [31:0] lo, span, sz;
    bit stop;
    h = 0; x = a;
    if (i == 0) begin
      sz = 32'h0040_0000; stop = 0;
      for (int b = 14; b <= 15; b++) if (!stop) begin if (c[b]) stop = 1; else sz = sz * 2; end
      lo = c & 32'h0FC0_0000;
      h  = c[3] && (a >= lo) && (a - lo < sz);
    end else if (i <= 4) begin
      sz = 32'h0020_0000; stop = 0;
      for (int b = 13; b <= 17; b++) if (!stop) begin if (c[b]) stop = 1; else sz = sz * 2; end
      lo = c & 32'h0FE0_0000;
      h  = c[3] && (a >= lo) && (a - lo < sz);
    end else if (i <= 7) begin
      lo   = c & 32'hFF00_0000;
      span = ~(32'h8000_0000 | (32'(c[19:13]) << 24));
      h    = c[12] && (a >= lo) && (a <= (lo | span));
      x    = (32'(c[7:0]) << 24) | (a - lo);
    end else begin
      lo   = c & 32'hFFE0_0000;
      span = ~(32'hF000_0000 | (32'(c[19:13]) << 21));
      h    = c[12] && (a >= lo) && (a <= (lo | span));
      x    = (32'(c[10:0]) << 21) | (a - lo);
    end
  endfunction

  function automatic exp_t ref_lookup(input logic [31:0] a);
    exp_t e;
    bit h;
    logic [31:0] x;
    e.hit = '0; e.addr = '0; e.miss = 1'b1;
    for (int i = NW - 1; i >= 0; i--) begin
      ref_win(i, shadow[i], a, h, x);
      if (h) begin
        e.hit = '0; e.hit[i] = 1'b1; e.addr = x; e.miss = 1'b0;
      end
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, expv);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    req_vld     = 1'b0;
    cfg_wr_en   = 1'b1;
    cfg_wr_idx  = 4'(idx);
    cfg_wr_data = d;
    if (idx < NW) shadow[idx] = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // Driver: issue a lookup and push the expected response
  task automatic lookup(input logic [31:0] a, input string tag);
    @(negedge clk);
    req_vld  = 1'b1;
    req_addr = a;
    exp_q.push_back(ref_lookup(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_vld = 1'b0;
    end
  endtask

  // Monitor: compare each response with the oldest expected item
  always @(negedge clk) begin
    if (live && rsp_vld) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected response", 64'(rsp_hit), 64'h0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rsp_hit, rsp_addr, rsp_miss} == e, t,
            {21'h0, rsp_hit, rsp_addr, rsp_miss}, {21'h0, e.hit, e.addr, e.miss});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NW-1:0] h0;
    logic [31:0]   a0;
    logic          m0;
    for (int i = 0; i < NW; i++) shadow[i] = '0;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_idx = '0; cfg_wr_data = '0;
    req_vld = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and everything disabled
    chk(rsp_vld == 1'b0 && rsp_hit == '0 && rsp_addr == '0 && rsp_miss == 1'b0,
        "R1 reset outputs", {rsp_vld, rsp_miss, 20'h0, rsp_hit, rsp_addr}, 64'h0);
    live = 1;
    lookup(32'h0000_0000, "R1");
    lookup(32'h4012_3454, "R1");
    lookup(32'hFFFF_FFFC, "R1");
    idle(2);

    // R2 R3: memory master windows and I/O window
    wr(5, 32'h400F_F012);
    wr(6, 32'h800F_9020);
    wr(7, 32'hC000_1005);
    lookup(32'h4012_3454, "R3 master1 translate");
    lookup(32'h4100_0000, "R2 master1 above end");
    lookup(32'h3FFF_FFFC, "R2 master1 below start");
    lookup(32'h83AB_CDE0, "R3 master2 masked translate");
    lookup(32'h8400_0000, "R2 master2 above end");
    lookup(32'hF000_0010, "R3 io window");
    idle(2);

    // R4 R5: target windows
    wr(8, 32'h202F_F003);
    wr(9, 32'h3000_17FF);
    lookup(32'h2021_0008, "R5 target1 translate");
    lookup(32'h2040_0000, "R4 target1 above end");
    lookup(32'h3123_4564, "R5 target2 translate");
    lookup(32'h2FFF_FFFC, "R4 target2 below start");
    idle(2);

    // R6: base memory bank sizes
    wr(0, 32'h0040_4008);
    lookup(32'h007F_FFFC, "R6 bank 4MB last");
    lookup(32'h0080_0000, "R6 bank 4MB end");
    wr(0, 32'h0040_8008);
    lookup(32'h00BF_FFFC, "R6 bank 8MB last");
    lookup(32'h00C0_0000, "R6 bank 8MB end");
    wr(0, 32'h0040_0008);
    lookup(32'h013F_FFFC, "R6 bank 16MB last");
    lookup(32'h0140_0000, "R6 bank 16MB end");
    wr(0, 32'h0040_0000);
    lookup(32'h0050_0000, "R6 bank disabled");
    wr(0, 32'h0040_0008);
    idle(1);

    // R7: SIMM banks
    wr(1, 32'h0200_2008);
    wr(2, 32'h0600_8008);
    wr(4, 32'h0800_0008);
    lookup(32'h021F_FFFC, "R7 simm0 2MB last");
    lookup(32'h0220_0000, "R7 simm0 2MB end");
    lookup(32'h067F_FFFC, "R7 simm1 8MB last");
    lookup(32'h0680_0000, "R7 simm1 8MB end");
    lookup(32'h0BFF_FFFC, "R7 simm3 64MB last");
    lookup(32'h0C00_0000, "R7 simm3 64MB end");
    idle(2);

    // R8: priority among overlapping windows
    wr(3, 32'h0100_2008);
    wr(6, 32'h020F_F000);
    wr(9, 32'h2000_1000);
    lookup(32'h0100_0010, "R8 bank over simm2");
    lookup(32'h0200_0100, "R8 simm0 over master2");
    lookup(32'h0230_0000, "R8 master2 alone");
    lookup(32'h2021_0008, "R8 target1 over target2");
    lookup(32'h2100_0000, "R8 target2 alone");
    idle(2);

    // R10: a write is seen by the next lookup; outputs hold while idle
    wr(5, 32'h400F_E012);
    lookup(32'h4012_3454, "R10 master1 disabled next lookup");
    lookup(32'h0050_0000, "R10 back to back");
    idle(2);
    h0 = rsp_hit; a0 = rsp_addr; m0 = rsp_miss;
    idle(3);
    chk(rsp_vld == 1'b0 && rsp_hit == h0 && rsp_addr == a0 && rsp_miss == m0,
        "R10 hold while idle", {rsp_vld, rsp_miss, 20'h0, rsp_hit, rsp_addr},
        {1'b0, m0, 20'h0, h0, a0});

    // R11: out-of-range writes change nothing
    wr(10, 32'hFFFF_FFFF);
    wr(13, 32'h0000_0000);
    wr(15, 32'hFFFF_FFFF);
    lookup(32'h0050_0000, "R11 bank kept");
    lookup(32'h83AB_CDE0, "R11 master slot");
    lookup(32'hF000_0010, "R11 io kept");
    lookup(32'h2021_0008, "R11 target kept");
    lookup(32'h1F00_0000, "R11 no window");
    idle(4);

    chk(exp_q.size() == 0, "R10 all responses returned", 64'(exp_q.size()), 64'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule